// File: doc/BRIEF.md
# Duplex Packet Word Decoder

The decoder takes 32-bit instruction words over a valid/ready handshake and groups them into packets. It sorts each word by its two parse bits (`[15:14]`). A word can be an ordinary instruction, a loop-end-marked instruction, the closing word of a packet, or a duplex. A duplex carries two 13-bit sub-instructions and always closes its packet. For a duplex, the block builds a 4-bit class from two bit fields that are not next to each other. It then emits the two sub-instructions as separate records, the slot-1 half first, and tags each one with its sub-instruction group.

Extender words emit no record. Each one gives a payload that is merged into the immediate of the next record. When a packet closes, the decoder reports:
- the number of words in the packet;
- any hardware-loop end implied by the loop marks on the first two words.

Reserved duplex classes, packets longer than the limit, and a stream that stops inside an open packet each raise their own one-cycle error pulse. Full decoding of opcodes inside each group is left to later stages. The block passes on raw fields and tags only.

Top module: `dpx_packet_decoder`

## Requirements
- R1: Parse bits `[15:14]` of a word classify it as follows: `00` duplex, `01` ordinary, `10` ordinary with loop mark, `11` last word of packet. A duplex or a `11` word closes the packet, and `pkt_done_o` pulses with the packet's last record.
- R2: The duplex class is `{word[31:29], word[13]}`. Bit 13 is the least significant bit.
- R3: The slot-0 sub-instruction is `word[12:0]` and the slot-1 sub-instruction is `word[28:16]`. Each appears zero-extended on `ins_word_o` with `ins_sub_o`=1.
- R4: A duplex accepted in cycle t emits the slot-1 record (`ins_slot1_o`=1) in cycle t+1 and the slot-0 record in cycle t+2. `word_ready_o` is low during t+1.
- R5: Group codes are L1=1, L2=2, S1=3, S2=4, A=5, and 0 for an ordinary word. The slot0/slot1 groups per class are:

  | Class | Slot 0 | Slot 1 |
  |---|---|---|
  | 0 | L1 | L1 |
  | 1 | L2 | L1 |
  | 2 | L2 | L2 |
  | 3 | A | A |
  | 4 | L1 | A |
  | 5 | L2 | A |
  | 6 | S1 | A |
  | 7 | S2 | A |
  | 8 | S1 | L1 |
  | 9 | S1 | L2 |
  | A | S1 | S1 |
  | B | S2 | S1 |
  | C | S2 | L1 |
  | D | S2 | L2 |
  | E | S2 | S2 |

  Class F is reserved. It pulses `err_class_o` and `pkt_done_o`, emits no record and keeps the handshake ready.
- R6: In a packet of exactly 2 words, a loop mark on word 0 gives `loop_end_o`=01. `loop_end_o` is nonzero only with `pkt_done_o`.
- R7: In a packet of 3 or more words, `loop_end_o` is `{mark on word 1, mark on word 0}`. Bit 1 never sets in shorter packets.
- R8: An extender is a non-duplex word with `[31:28]`=0. It emits no record and its payload is `{w[27:16], w[13:0], 6'b0}`. The next record in the packet gets `ins_imm_o` = payload OR its raw low 6 bits, with `ins_ext_o`=1. Otherwise `ins_imm_o` is the zero-extended raw immediate: `w[13:0]` for an ordinary word, the 13-bit field for a sub-instruction. A closing packet drops a pending payload.
- R9: A packet holds at most 4 words. A word accepted after 4 non-closing words is consumed, pulses `err_ovf_o` and discards the open packet.
- R10: `eos_i` while a packet is still open, counting a word accepted in the same cycle, pulses `err_incomplete_o` and discards the packet. The error pulses never overlap.
- R11: An ordinary word emits one record in the next cycle with `ins_word_o` equal to the word and group 0. `pkt_words_o` counts every accepted word of the packet, extenders included.
- R12: After reset, all record, packet and error outputs are 0 and `word_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | 32 | Instruction word |
| word_valid_i | input | 1 | Word present |
| word_ready_o | output | 1 | Word accepted when high with valid |
| eos_i | input | 1 | Input stream has ended |
| ins_valid_o | output | 1 | Record valid |
| ins_word_o | output | 32 | Raw word or zero-extended sub-instruction |
| ins_sub_o | output | 1 | Record is a sub-instruction |
| ins_slot1_o | output | 1 | Record is the slot-1 sub-instruction |
| ins_grp_o | output | 3 | Sub-instruction group code |
| ins_imm_o | output | 32 | Raw immediate, extender merged |
| ins_ext_o | output | 1 | Immediate carries an extender payload |
| pkt_done_o | output | 1 | Packet closed this cycle |
| pkt_words_o | output | 3 | Words in the closed packet |
| loop_end_o | output | 2 | Loop-end markers (bit0 loop 0, bit1 loop 1) |
| err_class_o | output | 1 | Reserved duplex class |
| err_ovf_o | output | 1 | Packet length exceeded |
| err_incomplete_o | output | 1 | Stream ended inside a packet |

## Verification
The assertions check properties that hold on every cycle:
- slot-1 is always followed by slot-0, with the input stalled in between;
- loop markers appear only with a packet close, and loop 1 only for packets of three or more words;
- packet lengths stay within the limit;
- a reserved class produces no record;
- the error pulses exclude one another;
- an extended ordinary record keeps its own low immediate bits.

The exact values only show up through the bench's scenarios compared against its reference model: group pairs per class, field extraction, merged immediates, loop-end codes for each mark pattern, overflow on the fifth word, and end-of-stream timing.

// File: rtl/dpx_pkg.sv
package dpx_pkg;
  localparam int WORD_W  = 32;
  localparam int SUB_W   = 13;
  localparam int NIMM_W  = 14;
  localparam int EXT_LOW = 6;

  typedef enum logic [1:0] {
    PB_DUPLEX = 2'b00,
    PB_MID    = 2'b01,
    PB_LOOP   = 2'b10,
    PB_END    = 2'b11
  } parse_e;

  typedef enum logic [2:0] {
    GRP_NONE = 3'd0,
    GRP_L1   = 3'd1,
    GRP_L2   = 3'd2,
    GRP_S1   = 3'd3,
    GRP_S2   = 3'd4,
    GRP_A    = 3'd5
  } grp_e;
endpackage

// File: rtl/dpx_word_class.sv
module dpx_word_class
  import dpx_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic              is_dup_o,
  output logic              is_end_o,
  output logic              is_mark_o,
  output logic              is_ext_o,
  output logic [3:0]        dup_class_o,
  output logic [SUB_W-1:0]  sub0_o,
  output logic [SUB_W-1:0]  sub1_o,
  output logic [WORD_W-1:0] ext_payload_o,
  output logic [NIMM_W-1:0] norm_imm_o
);
  parse_e pb;

  always_comb begin
    pb            = parse_e'(word_i[15:14]);
    is_dup_o      = (pb == PB_DUPLEX);
    is_end_o      = (pb == PB_END) || (pb == PB_DUPLEX);
    is_mark_o     = (pb == PB_LOOP);
    is_ext_o      = (pb != PB_DUPLEX) && (word_i[31:28] == 4'h0);
    dup_class_o   = {word_i[31:29], word_i[13]};
    sub0_o        = word_i[12:0];
    sub1_o        = word_i[28:16];
    ext_payload_o = {word_i[27:16], word_i[13:0], {EXT_LOW{1'b0}}};
    norm_imm_o    = word_i[13:0];
  end
endmodule

// File: rtl/dpx_group_map.sv
module dpx_group_map
  import dpx_pkg::*;
(
  input  logic [3:0] class_i,
  output grp_e       grp0_o,
  output grp_e       grp1_o,
  output logic       reserved_o
);
  always_comb begin
    reserved_o = 1'b0;
    unique case (class_i)
      4'h0: begin grp0_o = GRP_L1; grp1_o = GRP_L1; end
      4'h1: begin grp0_o = GRP_L2; grp1_o = GRP_L1; end
      4'h2: begin grp0_o = GRP_L2; grp1_o = GRP_L2; end
      4'h3: begin grp0_o = GRP_A;  grp1_o = GRP_A;  end
      4'h4: begin grp0_o = GRP_L1; grp1_o = GRP_A;  end
      4'h5: begin grp0_o = GRP_L2; grp1_o = GRP_A;  end
      4'h6: begin grp0_o = GRP_S1; grp1_o = GRP_A;  end
      4'h7: begin grp0_o = GRP_S2; grp1_o = GRP_A;  end
      4'h8: begin grp0_o = GRP_S1; grp1_o = GRP_L1; end
      4'h9: begin grp0_o = GRP_S1; grp1_o = GRP_L2; end
      4'ha: begin grp0_o = GRP_S1; grp1_o = GRP_S1; end
      4'hb: begin grp0_o = GRP_S2; grp1_o = GRP_S1; end
      4'hc: begin grp0_o = GRP_S2; grp1_o = GRP_L1; end
      4'hd: begin grp0_o = GRP_S2; grp1_o = GRP_L2; end
      4'he: begin grp0_o = GRP_S2; grp1_o = GRP_S2; end
      default: begin grp0_o = GRP_NONE; grp1_o = GRP_NONE; reserved_o = 1'b1; end
    endcase
  end
endmodule

// File: rtl/dpx_loop_mark.sv
module dpx_loop_mark #(
  parameter int CNT_W = 3
) (
  input  logic [CNT_W-1:0] words_i,
  input  logic             mark0_i,
  input  logic             mark1_i,
  output logic [1:0]       loop_o
);
  always_comb begin
    if (words_i >= CNT_W'(3))      loop_o = {mark1_i, mark0_i};
    else if (words_i == CNT_W'(2)) loop_o = {1'b0, mark0_i};
    else                           loop_o = 2'b00;
  end
endmodule

// File: rtl/dpx_imm_merge.sv
module dpx_imm_merge
  import dpx_pkg::*;
#(
  parameter int RAW_W = SUB_W
) (
  input  logic [RAW_W-1:0]  raw_i,
  input  logic              ext_pend_i,
  input  logic [WORD_W-1:0] ext_val_i,
  output logic [WORD_W-1:0] imm_o
);
  always_comb begin
    if (ext_pend_i) imm_o = ext_val_i | WORD_W'(raw_i[EXT_LOW-1:0]);
    else            imm_o = WORD_W'(raw_i);
  end
endmodule

// File: rtl/dpx_packet_decoder.sv
module dpx_packet_decoder
  import dpx_pkg::*;
#(
  parameter int MAX_WORDS = 4,
  localparam int CNT_W    = $clog2(MAX_WORDS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       word_i,
  input  logic              word_valid_i,
  output logic              word_ready_o,
  input  logic              eos_i,
  output logic              ins_valid_o,
  output logic [31:0]       ins_word_o,
  output logic              ins_sub_o,
  output logic              ins_slot1_o,
  output logic [2:0]        ins_grp_o,
  output logic [31:0]       ins_imm_o,
  output logic              ins_ext_o,
  output logic              pkt_done_o,
  output logic [CNT_W-1:0]  pkt_words_o,
  output logic [1:0]        loop_end_o,
  output logic              err_class_o,
  output logic              err_ovf_o,
  output logic              err_incomplete_o
);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_WORDS);

  // classification
  logic              wc_dup, wc_end, wc_mark, wc_ext;
  logic [3:0]        wc_class;
  logic [SUB_W-1:0]  wc_sub0, wc_sub1;
  logic [WORD_W-1:0] wc_payload;
  logic [NIMM_W-1:0] wc_nimm;

  dpx_word_class u_class (
    .word_i        (word_i),
    .is_dup_o      (wc_dup),
    .is_end_o      (wc_end),
    .is_mark_o     (wc_mark),
    .is_ext_o      (wc_ext),
    .dup_class_o   (wc_class),
    .sub0_o        (wc_sub0),
    .sub1_o        (wc_sub1),
    .ext_payload_o (wc_payload),
    .norm_imm_o    (wc_nimm)
  );

  grp_e gm_grp0, gm_grp1;
  logic gm_rsvd;

  dpx_group_map u_grp (
    .class_i    (wc_class),
    .grp0_o     (gm_grp0),
    .grp1_o     (gm_grp1),
    .reserved_o (gm_rsvd)
  );

  // packet state
  logic [CNT_W-1:0]  cnt_q;
  logic              mark0_q, mark1_q;
  logic              ext_pend_q;
  logic [WORD_W-1:0] ext_val_q;
  logic              hold_q;
  logic [SUB_W-1:0]  hold_sub_q;
  grp_e              hold_grp_q;
  logic [CNT_W-1:0]  hold_words_q;
  logic [1:0]        hold_loop_q;

  logic             accept, full, closes, open_next;
  logic [CNT_W-1:0] cnt_inc;
  logic             mark0_n, mark1_n;
  logic [1:0]       loop_res;

  assign word_ready_o = !hold_q;
  assign accept       = word_valid_i && word_ready_o;
  assign full         = (cnt_q == MAX_CNT);
  assign cnt_inc      = cnt_q + CNT_W'(1);
  assign mark0_n      = (cnt_q == CNT_W'(0)) ? wc_mark : mark0_q;
  assign mark1_n      = (cnt_q == CNT_W'(1)) ? wc_mark : mark1_q;
  assign closes       = full || wc_end;
  assign open_next    = accept ? !closes : (cnt_q != CNT_W'(0));

  dpx_loop_mark #(.CNT_W(CNT_W)) u_loop (
    .words_i (cnt_inc),
    .mark0_i (mark0_n),
    .mark1_i (mark1_n),
    .loop_o  (loop_res)
  );

  // immediate merge: index 0 ordinary word, index 1 slot-1 sub-instruction
  logic [WORD_W-1:0] imm_m [2];

  for (genvar g = 0; g < 2; g++) begin : g_imm
    if (g == 0) begin : g_norm
      dpx_imm_merge #(.RAW_W(NIMM_W)) u_m (
        .raw_i      (wc_nimm),
        .ext_pend_i (ext_pend_q),
        .ext_val_i  (ext_val_q),
        .imm_o      (imm_m[g])
      );
    end else begin : g_sub
      dpx_imm_merge #(.RAW_W(SUB_W)) u_m (
        .raw_i      (wc_sub1),
        .ext_pend_i (ext_pend_q),
        .ext_val_i  (ext_val_q),
        .imm_o      (imm_m[g])
      );
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q            <= '0;
      mark0_q          <= 1'b0;
      mark1_q          <= 1'b0;
      ext_pend_q       <= 1'b0;
      ext_val_q        <= '0;
      hold_q           <= 1'b0;
      hold_sub_q       <= '0;
      hold_grp_q       <= GRP_NONE;
      hold_words_q     <= '0;
      hold_loop_q      <= '0;
      ins_valid_o      <= 1'b0;
      ins_word_o       <= '0;
      ins_sub_o        <= 1'b0;
      ins_slot1_o      <= 1'b0;
      ins_grp_o        <= '0;
      ins_imm_o        <= '0;
      ins_ext_o        <= 1'b0;
      pkt_done_o       <= 1'b0;
      pkt_words_o      <= '0;
      loop_end_o       <= '0;
      err_class_o      <= 1'b0;
      err_ovf_o        <= 1'b0;
      err_incomplete_o <= 1'b0;
    end else begin
      ins_valid_o      <= 1'b0;
      ins_ext_o        <= 1'b0;
      pkt_done_o       <= 1'b0;
      loop_end_o       <= '0;
      err_class_o      <= 1'b0;
      err_ovf_o        <= 1'b0;
      err_incomplete_o <= 1'b0;

      if (hold_q) begin
        // second half of a duplex
        hold_q      <= 1'b0;
        ins_valid_o <= 1'b1;
        ins_word_o  <= WORD_W'(hold_sub_q);
        ins_sub_o   <= 1'b1;
        ins_slot1_o <= 1'b0;
        ins_grp_o   <= hold_grp_q;
        ins_imm_o   <= WORD_W'(hold_sub_q);
        pkt_done_o  <= 1'b1;
        pkt_words_o <= hold_words_q;
        loop_end_o  <= hold_loop_q;
      end else if (accept) begin
        if (full) begin
          err_ovf_o  <= 1'b1;
          cnt_q      <= '0;
          mark0_q    <= 1'b0;
          mark1_q    <= 1'b0;
          ext_pend_q <= 1'b0;
        end else if (wc_dup) begin
          cnt_q      <= '0;
          mark0_q    <= 1'b0;
          mark1_q    <= 1'b0;
          ext_pend_q <= 1'b0;
          if (gm_rsvd) begin
            err_class_o <= 1'b1;
            pkt_done_o  <= 1'b1;
            pkt_words_o <= cnt_inc;
            loop_end_o  <= loop_res;
          end else begin
            ins_valid_o  <= 1'b1;
            ins_word_o   <= WORD_W'(wc_sub1);
            ins_sub_o    <= 1'b1;
            ins_slot1_o  <= 1'b1;
            ins_grp_o    <= gm_grp1;
            ins_imm_o    <= imm_m[1];
            ins_ext_o    <= ext_pend_q;
            hold_q       <= 1'b1;
            hold_sub_q   <= wc_sub0;
            hold_grp_q   <= gm_grp0;
            hold_words_q <= cnt_inc;
            hold_loop_q  <= loop_res;
          end
        end else begin
          if (wc_ext) begin
            ext_pend_q <= 1'b1;
            ext_val_q  <= wc_payload;
          end else begin
            ins_valid_o <= 1'b1;
            ins_word_o  <= word_i;
            ins_sub_o   <= 1'b0;
            ins_slot1_o <= 1'b0;
            ins_grp_o   <= GRP_NONE;
            ins_imm_o   <= imm_m[0];
            ins_ext_o   <= ext_pend_q;
            ext_pend_q  <= 1'b0;
          end
          if (wc_end) begin
            pkt_done_o  <= 1'b1;
            pkt_words_o <= cnt_inc;
            loop_end_o  <= loop_res;
            cnt_q       <= '0;
            mark0_q     <= 1'b0;
            mark1_q     <= 1'b0;
            ext_pend_q  <= 1'b0;
          end else begin
            cnt_q   <= cnt_inc;
            mark0_q <= mark0_n;
            mark1_q <= mark1_n;
          end
        end
      end

      if (eos_i && open_next) begin
        err_incomplete_o <= 1'b1;
        cnt_q            <= '0;
        mark0_q          <= 1'b0;
        mark1_q          <= 1'b0;
        ext_pend_q       <= 1'b0;
      end
    end
  end

  AST_SLOT_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_o && ins_slot1_o) |=> (ins_valid_o && ins_sub_o && !ins_slot1_o)); // R4
  AST_SPLIT_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_o && ins_slot1_o) |-> !word_ready_o); // R4
  AST_LOOP_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop_end_o != 2'b00) |-> pkt_done_o); // R6
  AST_LOOP1_LONG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_done_o && (pkt_words_o < CNT_W'(3))) |-> !loop_end_o[1]); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_done_o |-> (pkt_words_o <= MAX_CNT) && (pkt_words_o != CNT_W'(0))); // R9
  AST_CLASS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_class_o |-> (!ins_valid_o && pkt_done_o)); // R5
  AST_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({err_class_o, err_ovf_o, err_incomplete_o})); // R10
  AST_EXT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_o && ins_ext_o && !ins_sub_o) |-> (ins_imm_o[EXT_LOW-1:0] == ins_word_o[EXT_LOW-1:0])); // R8
endmodule

// File: tb/sim_dpx_packet_decoder.sv
`timescale 1ns/1ps
module sim_dpx_packet_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] word = '0;
  logic        word_valid = 1'b0;
  logic        eos = 1'b0;
  logic        word_ready;
  logic        ins_valid, ins_sub, ins_slot1, ins_ext;
  logic [31:0] ins_word, ins_imm;
  logic [2:0]  ins_grp;
  logic        pkt_done;
  logic [2:0]  pkt_words;
  logic [1:0]  loop_end;
  logic        err_class, err_ovf, err_inc;

  always #10 clk = ~clk;

  dpx_packet_decoder u0 (
    .clk_i(clk), .rst_ni(rst_n), .word_i(word), .word_valid_i(word_valid),
    .word_ready_o(word_ready), .eos_i(eos), .ins_valid_o(ins_valid),
    .ins_word_o(ins_word), .ins_sub_o(ins_sub), .ins_slot1_o(ins_slot1),
    .ins_grp_o(ins_grp), .ins_imm_o(ins_imm), .ins_ext_o(ins_ext),
    .pkt_done_o(pkt_done), .pkt_words_o(pkt_words), .loop_end_o(loop_end),
    .err_class_o(err_class), .err_ovf_o(err_ovf), .err_incomplete_o(err_inc)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // group code per class: returns {slot0, slot1}
  function automatic logic [5:0] grp_pair(input logic [3:0] c);
    case (c)
      4'h0: return {3'd1, 3'd1};
      4'h1: return {3'd2, 3'd1};
      4'h2: return {3'd2, 3'd2};
      4'h3: return {3'd5, 3'd5};
      4'h4: return {3'd1, 3'd5};
      4'h5: return {3'd2, 3'd5};
      4'h6: return {3'd3, 3'd5};
      4'h7: return {3'd4, 3'd5};
      4'h8: return {3'd3, 3'd1};
      4'h9: return {3'd3, 3'd2};
      4'ha: return {3'd3, 3'd3};
      4'hb: return {3'd4, 3'd3};
      4'hc: return {3'd4, 3'd1};
      4'hd: return {3'd4, 3'd2};
      4'he: return {3'd4, 3'd4};
      default: return 6'd0;
    endcase
  endfunction

  // reference model
  int          m_cnt;
  bit          m_m0, m_m1, m_ext, m_hold;
  logic [31:0] m_extv;
  logic [12:0] m_hsub;
  logic [2:0]  m_hgrp;
  int          m_hwords;
  logic [1:0]  m_hloop;
  bit          e_valid, e_sub, e_slot1, e_ext, e_done, e_ecls, e_eovf, e_einc;
  logic [31:0] e_word, e_imm;
  logic [2:0]  e_grp;
  int          e_words;
  logic [1:0]  e_loop;

  function automatic logic [31:0] mimm(input logic [31:0] raw, input bit ext, input logic [31:0] v);
    return ext ? (v | {26'd0, raw[5:0]}) : raw;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_m0 = 0; m_m1 = 0; m_ext = 0; m_hold = 0; m_extv = 0;
      m_hsub = 0; m_hgrp = 0; m_hwords = 0; m_hloop = 0;
      e_valid = 0; e_sub = 0; e_slot1 = 0; e_ext = 0; e_done = 0;
      e_ecls = 0; e_eovf = 0; e_einc = 0; e_word = 0; e_imm = 0; e_grp = 0;
      e_words = 0; e_loop = 0;
    end else begin
      e_valid = 0; e_ext = 0; e_done = 0; e_ecls = 0; e_eovf = 0; e_einc = 0; e_loop = 0;
      if (m_hold) begin
        m_hold = 0;
        e_valid = 1; e_sub = 1; e_slot1 = 0; e_word = {19'd0, m_hsub};
        e_imm = {19'd0, m_hsub}; e_grp = m_hgrp;
        e_done = 1; e_words = m_hwords; e_loop = m_hloop;
      end else if (word_valid) begin
        if (m_cnt == 4) begin
          e_eovf = 1; m_cnt = 0; m_m0 = 0; m_m1 = 0; m_ext = 0;
        end else begin
          int n;
          logic [1:0] p;
          logic [1:0] lp;
          p = word[15:14];
          n = m_cnt + 1;
          if (m_cnt == 0) m_m0 = (p == 2'b10);
          if (m_cnt == 1) m_m1 = (p == 2'b10);
          lp = (n >= 3) ? {m_m1, m_m0} : (n == 2) ? {1'b0, m_m0} : 2'b00;
          if (p == 2'b00) begin
            logic [3:0] c;
            c = {word[31:29], word[13]};
            if (c == 4'hf) begin
              e_ecls = 1; e_done = 1; e_words = n; e_loop = lp;
            end else begin
              e_valid = 1; e_sub = 1; e_slot1 = 1; e_word = {19'd0, word[28:16]};
              e_imm = mimm({19'd0, word[28:16]}, m_ext, m_extv); e_ext = m_ext;
              e_grp = grp_pair(c)[2:0];
              m_hold = 1; m_hsub = word[12:0]; m_hgrp = grp_pair(c)[5:3];
              m_hwords = n; m_hloop = lp;
            end
            m_cnt = 0; m_m0 = 0; m_m1 = 0; m_ext = 0;
          end else begin
            if (word[31:28] == 4'h0) begin
              m_ext = 1; m_extv = {word[27:16], word[13:0], 6'd0};
            end else begin
              e_valid = 1; e_sub = 0; e_slot1 = 0; e_word = word; e_grp = 0;
              e_imm = mimm({18'd0, word[13:0]}, m_ext, m_extv); e_ext = m_ext;
              m_ext = 0;
            end
            if (p == 2'b11) begin
              e_done = 1; e_words = n; e_loop = lp;
              m_cnt = 0; m_m0 = 0; m_m1 = 0; m_ext = 0;
            end else m_cnt = n;
          end
        end
      end
      if (eos && m_cnt != 0) begin
        e_einc = 1; m_cnt = 0; m_m0 = 0; m_m1 = 0; m_ext = 0;
      end
    end
  end

  bit run_cmp = 0;

  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      chk(word_ready == !m_hold, "R4 ready", {31'd0, word_ready}, {31'd0, !m_hold});
      chk(ins_valid == e_valid, "R11 ins_valid", {31'd0, ins_valid}, {31'd0, e_valid});
      if (e_valid && ins_valid) begin
        chk(ins_word == e_word, e_sub ? "R3 sub field" : "R11 word", ins_word, e_word);
        chk(ins_sub == e_sub && ins_slot1 == e_slot1, "R4 slot tag",
            {30'd0, ins_sub, ins_slot1}, {30'd0, e_sub, e_slot1});
        chk(ins_grp == e_grp, "R5 R2 group", {29'd0, ins_grp}, {29'd0, e_grp});
        chk(ins_imm == e_imm && ins_ext == e_ext, "R8 imm", ins_imm, e_imm);
      end
      chk(pkt_done == e_done, "R1 pkt_done", {31'd0, pkt_done}, {31'd0, e_done});
      if (e_done && pkt_done) begin
        chk(pkt_words == 3'(e_words), "R11 pkt_words", {29'd0, pkt_words}, e_words);
        chk(loop_end == e_loop, (e_words >= 3) ? "R7 loop_end" : "R6 loop_end",
            {30'd0, loop_end}, {30'd0, e_loop});
      end
      chk(err_class == e_ecls, "R5 err_class", {31'd0, err_class}, {31'd0, e_ecls});
      chk(err_ovf == e_eovf, "R9 err_ovf", {31'd0, err_ovf}, {31'd0, e_eovf});
      chk(err_inc == e_einc, "R10 err_incomplete", {31'd0, err_inc}, {31'd0, e_einc});
    end
  end

  // stimulus helpers
  function automatic logic [31:0] nw(input logic [1:0] p, input logic [31:0] b);
    return {4'h9 | b[31:28], b[27:16], p, b[13:0]};
  endfunction
  function automatic logic [31:0] xw(input logic [1:0] p, input logic [25:0] pay);
    return {4'h0, pay[25:14], p, pay[13:0]};
  endfunction
  function automatic logic [31:0] dw(input logic [3:0] c, input logic [12:0] s1, input logic [12:0] s0);
    return {c[3:1], s1, 2'b00, c[0], s0};
  endfunction

  task automatic put(input logic [31:0] w, input bit e = 0);
    @(negedge clk);
    word = w; word_valid = 1; eos = e;
    while (!word_ready) @(negedge clk);
    @(posedge clk);
  endtask
  task automatic idle(input int n, input bit e = 0);
    @(negedge clk);
    word_valid = 0; eos = e;
    @(posedge clk);
    @(negedge clk);
    eos = 0;
    repeat (n) @(negedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(word_ready == 1'b1, "R12 ready", {31'd0, word_ready}, 32'd1);
    chk({ins_valid, pkt_done, err_class, err_ovf, err_inc, loop_end} == 7'd0, "R12 outputs",
        {25'd0, ins_valid, pkt_done, err_class, err_ovf, err_inc, loop_end}, 32'd0);
    rst_n = 1;
    run_cmp = 1;
    @(negedge clk);

    put(nw(2'b11, 32'h1234_5678)); idle(2);                            // R11
    put(nw(2'b10, 32'h1111_0001)); put(nw(2'b11, 32'h2222_0002)); idle(2); // R6
    put(nw(2'b10, 32'h1)); put(nw(2'b10, 32'h2)); put(nw(2'b11, 32'h3)); idle(2); // R7 both
    put(nw(2'b01, 32'h1)); put(nw(2'b10, 32'h2)); put(nw(2'b11, 32'h3)); idle(2); // R7 loop1
    put(nw(2'b10, 32'h1)); put(nw(2'b01, 32'h2)); put(nw(2'b01, 32'h3));
    put(nw(2'b11, 32'h4)); idle(2);                                    // R7 loop0
    for (int c = 0; c < 16; c++) begin                                 // R2 R3 R5
      put(dw(4'(c), 13'h1abc - 13'(c), 13'h0155 + 13'(c)));
      idle(2);
    end
    put(nw(2'b10, 32'h5)); put(dw(4'h6, 13'h1fff, 13'h0001)); idle(2); // R6 with duplex
    put(xw(2'b01, 26'h2a5_5a5a)); put(nw(2'b11, 32'h0000_3fff)); idle(2); // R8
    put(xw(2'b01, 26'h155_aaaa)); put(dw(4'h9, 13'h17c5, 13'h0f0f)); idle(2); // R8 sub
    put(xw(2'b11, 26'h3ff_ffff)); put(nw(2'b11, 32'h7)); idle(2);      // R8 dropped at close
    for (int i = 0; i < 4; i++) put(nw(2'b01, 32'(i)));
    put(nw(2'b11, 32'h9)); idle(2);                                    // R9
    put(nw(2'b11, 32'ha)); idle(2);
    put(nw(2'b01, 32'h1)); put(nw(2'b01, 32'h2)); idle(1, 1'b1); idle(2); // R10
    put(nw(2'b01, 32'h3), 1'b1); idle(2);                              // R10 same cycle
    put(nw(2'b11, 32'h4), 1'b1); idle(2);                              // R10 closed, no error

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] w;
      int k;
      @(negedge clk);
      k = $urandom % 8;
      w = $urandom;
      if (k == 0) w[15:14] = 2'b00;
      else if (k < 3) w[15:14] = 2'b11;
      if (($urandom % 6) == 0 && w[15:14] != 2'b00) w[31:28] = 4'h0;
      word = w;
      word_valid = (($urandom % 4) != 0);
      eos = (($urandom % 40) == 0);
    end
    idle(4);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule